// File: doc/BRIEF.md
# AAL5 Receive Frame Tracker

This block sits between a cell-level receive path and a frame-level consumer for one virtual circuit. Cells arrive on a 32-bit word bus. Each cell is one header word, marked by a start-of-cell strobe, followed by twelve payload words. The block stores the cells and groups them into AAL5 frames. It runs CRC-32 over each frame as the words arrive and checks the trailer. It then replays the words downstream with frame-level strobes: start of frame, end of frame, data enable, and a CRC verdict on the last trailer word.

The end-of-frame strobe has to mark the last real payload word. That word can sit in the cell before the one carrying the trailer. The block therefore holds back a cell that is not the last of its frame until the following cell is complete. By then the byte length in the trailer is known wherever it is needed, and the strobe can be placed before those words leave.

A ready signal from downstream is turned into a ready signal for upstream. Words already buffered keep flowing while ready is low. Upstream must not begin a new cell while the block's ready output is low.

Top module: `aal5_frame_rx`

## Requirements
- R1: A word with `in_vld` and `in_soc` high is a cell header, and the next 12 valid words are its payload. Bit 1 of the header word marks the last cell of a frame. No other header bit affects framing. The header word is forwarded on `out_data` with `out_den` low.
- R2: `out_sof` is high for exactly one output word: the header of the first cell of each frame. It is low on the headers of the other cells.
- R3: `out_den` is high on every payload word and on the two trailer words (the last two words of the final cell). It is low on header words and on pad words, which lie between the last payload word and the trailer.
- R4: `out_eof` is high on exactly one word per frame. That word is payload word number ceil(L/4)-1, counting from 0 across all cells of the frame, where L is the low 16 bits of the first trailer word. The word can lie in the second-to-last cell.
- R5: The block computes CRC-32 MSB-first over all frame words except the last. It uses polynomial 0x04C11DB7 with the register preset to all ones. Each word is processed as four bytes, most significant byte first. `out_crc_vld` is high only on the final trailer word, and `out_crc_ok` is high there exactly when that word equals the inverted CRC.
- R6: Every accepted word leaves on `out_data` with `out_vld` high, unchanged and in arrival order.
- R7: A start-of-cell strobe inside an open cell discards the partial cell. The discarded cell is never output and does not affect the frame CRC.
- R8: Valid words without `in_soc` arriving while no cell is open are ignored.
- R9: `in_rdy` is low in the cycle after `out_rdy` is low, and also when fewer than two cell slots are free. Buffered words keep leaving while `out_rdy` is low.
- R10: During reset all outputs, including `in_rdy`, are low.
- R11: When upstream starts cells only while `in_rdy` is high, no completed cell overwrites a cell that has not yet been output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_soc | input | 1 | Input word is a cell header |
| in_data | input | 32 | Input word |
| in_rdy | output | 1 | Upstream may begin a new cell |
| out_rdy | input | 1 | Downstream can accept new cells |
| out_vld | output | 1 | Output word present |
| out_data | output | 32 | Output word (zero when idle) |
| out_den | output | 1 | Output word is payload or trailer |
| out_sof | output | 1 | Header of the first cell of a frame |
| out_eof | output | 1 | Last payload word of the frame |
| out_crc_vld | output | 1 | Final trailer word, CRC verdict valid |
| out_crc_ok | output | 1 | Frame CRC matched |

## Verification
A slot flag that is wrong, or a read pointer out of step, shows within one cell time: a word appears twice, goes missing, or comes out of order on `out_data`. A wrong frame word count or a stale length moves `out_eof` and the `out_den` edge off by whole words, and the next frame shows the error in its first cell. A CRC checkpoint that is not restored after an aborted cell turns `out_crc_ok` low on the next trailer, up to two cells later. Lengths are chosen so that the end strobe falls on both sides of a cell boundary.

// File: rtl/aal5_rx_pkg.sv
package aal5_rx_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // per-slot descriptor written when a cell completes
  typedef struct packed {
    logic        eom;   // cell closes its frame
    logic [15:0] len;   // payload byte length (valid when eom)
    logic        ok;    // CRC verdict (valid when eom)
  } cell_meta_t;

  // advance the CRC register by one 32-bit word, most significant bit first
  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/aal5_cell_rx.sv
module aal5_cell_rx
  import aal5_rx_pkg::*;
#(
  parameter int CELL_PAY = 12,
  parameter int SLOTS    = 4,
  parameter int EOM_BIT  = 1,
  localparam int IDX_W   = $clog2(CELL_PAY + 1),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ADDR_W  = SLOT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_soc,
  input  logic [31:0]       in_data,
  input  logic [SLOTS-1:0]  slot_full,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              commit,
  output logic [SLOT_W-1:0] commit_slot,
  output cell_meta_t        commit_meta
);

  logic [IDX_W-1:0]  wi;          // 0: no open cell, else next payload index + 1
  logic [SLOT_W-1:0] w_slot;
  logic              hdr_eom;
  logic [15:0]       len_tmp;
  logic [31:0]       crc_frame;   // checkpoint at the last completed cell
  logic [31:0]       crc_work;    // running value inside the open cell
  logic [31:0]       crc_nx;
  logic              hdr_take, pay_take, last;

  assign hdr_take = in_vld && in_soc && !slot_full[w_slot];
  assign pay_take = in_vld && !in_soc && (wi != '0);
  assign last     = pay_take && (wi == IDX_W'(CELL_PAY));
  assign crc_nx   = crc32_word(crc_work, in_data);

  assign wr_en       = hdr_take || pay_take;
  assign wr_addr     = {w_slot, (hdr_take ? IDX_W'(0) : wi)};
  assign wr_data     = in_data;
  assign commit      = last;
  assign commit_slot = w_slot;
  assign commit_meta = '{eom: hdr_eom, len: len_tmp, ok: (in_data == ~crc_work)};

  always_ff @(posedge clk) begin
    if (rst) begin
      wi        <= '0;
      w_slot    <= '0;
      hdr_eom   <= 1'b0;
      len_tmp   <= '0;
      crc_frame <= '1;
      crc_work  <= '1;
    end else if (in_vld && in_soc) begin
      // a header always restarts; partial cells are dropped
      wi       <= hdr_take ? IDX_W'(1) : '0;
      hdr_eom  <= in_data[EOM_BIT];
      crc_work <= crc_frame;
    end else if (pay_take) begin
      wi       <= last ? '0 : wi + IDX_W'(1);
      crc_work <= crc_nx;
      if (wi == IDX_W'(CELL_PAY - 1)) len_tmp <= in_data[15:0];
      if (last) begin
        w_slot    <= w_slot + SLOT_W'(1);
        crc_frame <= hdr_eom ? '1 : crc_nx;
      end
    end
  end

endmodule

// File: rtl/aal5_cell_store.sv
module aal5_cell_store
  import aal5_rx_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int IDX_W   = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = SLOT_W + IDX_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              commit,
  input  logic [SLOT_W-1:0] commit_slot,
  input  cell_meta_t        commit_meta,
  input  logic              release_cell,
  input  logic [SLOT_W-1:0] release_slot,
  output logic [SLOTS-1:0]  full,
  output cell_meta_t        meta [SLOTS]
);

  logic [31:0] mem [DEPTH];

  // plain write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= '0;
      for (int s = 0; s < SLOTS; s++) meta[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (commit && commit_slot == SLOT_W'(s)) begin
          full[s] <= 1'b1;
          meta[s] <= commit_meta;
        end else if (release_cell && release_slot == SLOT_W'(s)) begin
          full[s] <= 1'b0;
        end
      end
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> !full[commit_slot]);

  // R6
  rd_full_chk: assert property (@(posedge clk) disable iff (rst)
    release_cell |-> full[release_slot]);

endmodule

// File: rtl/aal5_frame_tx.sv
module aal5_frame_tx
  import aal5_rx_pkg::*;
#(
  parameter int CELL_PAY = 12,
  parameter int SLOTS    = 4,
  parameter int FCNT_W   = 16,
  localparam int IDX_W   = $clog2(CELL_PAY + 1),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ADDR_W  = SLOT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOTS-1:0]  full,
  input  cell_meta_t        meta [SLOTS],
  input  logic [31:0]       rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              release_cell,
  output logic [SLOT_W-1:0] release_slot,
  output logic              out_vld,
  output logic [31:0]       out_data,
  output logic              out_den,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_crc_vld,
  output logic              out_crc_ok
);

  logic              rd_act;
  logic [SLOT_W-1:0] r_slot, nxt;
  logic [IDX_W-1:0]  ri, idx;
  logic [FCNT_W-1:0] fcnt;          // payload-area words already sent in frame
  logic              sof_pend;
  logic              can_start, issue, pay, cur_eom, len_known;
  logic [15:0]       len_sel;
  logic [FCNT_W:0]   pcount, fpos;
  logic              in_pay, trailer, eof_w, den_w, cv_w;
  logic              vld_q, den_q, sof_q, eof_q, cv_q, ok_q;

  assign nxt       = r_slot + SLOT_W'(1);
  assign cur_eom   = meta[r_slot].eom;
  // a non-final cell waits until the following cell is complete
  assign can_start = !rd_act && full[r_slot] && (cur_eom || full[nxt]);
  assign issue     = rd_act || can_start;
  assign idx       = rd_act ? ri : '0;
  assign pay       = (idx != '0);

  assign len_known = cur_eom || (full[nxt] && meta[nxt].eom);
  assign len_sel   = cur_eom ? meta[r_slot].len : meta[nxt].len;
  assign pcount    = (FCNT_W+1)'(({1'b0, len_sel} + 17'd3) >> 2);
  assign fpos      = {1'b0, fcnt};

  assign in_pay  = !len_known || (fpos < pcount);
  assign trailer = cur_eom && (idx >= IDX_W'(CELL_PAY - 1));
  assign eof_w   = pay && len_known && ((fpos + 1'b1) == pcount);
  assign den_w   = pay && (in_pay || trailer);
  assign cv_w    = cur_eom && (idx == IDX_W'(CELL_PAY));

  assign rd_en        = issue;
  assign rd_addr      = {r_slot, idx};
  assign release_cell = issue && (idx == IDX_W'(CELL_PAY));
  assign release_slot = r_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act   <= 1'b0;
      r_slot   <= '0;
      ri       <= '0;
      fcnt     <= '0;
      sof_pend <= 1'b1;
      vld_q    <= 1'b0;
      den_q    <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      cv_q     <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      vld_q <= issue;
      den_q <= issue && den_w;
      sof_q <= issue && !pay && sof_pend;
      eof_q <= issue && eof_w;
      cv_q  <= issue && cv_w;
      ok_q  <= issue && cv_w && meta[r_slot].ok;
      if (issue) begin
        if (!pay) sof_pend <= 1'b0;
        if (pay)  fcnt <= fcnt + 1'b1;
        if (release_cell) begin
          rd_act <= 1'b0;
          ri     <= '0;
          r_slot <= nxt;
          if (cur_eom) begin
            fcnt     <= '0;
            sof_pend <= 1'b1;
          end
        end else begin
          rd_act <= 1'b1;
          ri     <= idx + IDX_W'(1);
        end
      end
    end
  end

  assign out_vld     = vld_q;
  assign out_data    = vld_q ? rd_data : '0;
  assign out_den     = den_q;
  assign out_sof     = sof_q;
  assign out_eof     = eof_q;
  assign out_crc_vld = cv_q;
  assign out_crc_ok  = ok_q;

  // R2
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |=> !out_sof);

  // R4
  eof_den_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (out_den && out_vld));

  // R5
  crc_vld_chk: assert property (@(posedge clk) disable iff (rst)
    out_crc_vld |-> (out_vld && out_den && !out_sof));

endmodule

// File: rtl/aal5_frame_rx.sv
module aal5_frame_rx
  import aal5_rx_pkg::*;
#(
  parameter int CELL_PAY = 12,
  parameter int SLOTS    = 4,
  parameter int EOM_BIT  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_vld,
  input  logic        in_soc,
  input  logic [31:0] in_data,
  output logic        in_rdy,
  input  logic        out_rdy,
  output logic        out_vld,
  output logic [31:0] out_data,
  output logic        out_den,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_crc_vld,
  output logic        out_crc_ok
);

  localparam int IDX_W  = $clog2(CELL_PAY + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ADDR_W = SLOT_W + IDX_W;

  logic              wr_en, rd_en, commit, release_cell;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_data;
  logic [SLOT_W-1:0] commit_slot, release_slot;
  cell_meta_t        commit_meta;
  logic [SLOTS-1:0]  full;
  cell_meta_t        meta [SLOTS];

  aal5_cell_rx #(.CELL_PAY(CELL_PAY), .SLOTS(SLOTS), .EOM_BIT(EOM_BIT)) u_rx (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_soc(in_soc), .in_data(in_data),
    .slot_full(full), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_slot(commit_slot), .commit_meta(commit_meta)
  );

  aal5_cell_store #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .commit(commit), .commit_slot(commit_slot), .commit_meta(commit_meta),
    .release_cell(release_cell), .release_slot(release_slot),
    .full(full), .meta(meta)
  );

  aal5_frame_tx #(.CELL_PAY(CELL_PAY), .SLOTS(SLOTS)) u_tx (
    .clk(clk), .rst(rst), .full(full), .meta(meta), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .release_cell(release_cell),
    .release_slot(release_slot), .out_vld(out_vld), .out_data(out_data),
    .out_den(out_den), .out_sof(out_sof), .out_eof(out_eof),
    .out_crc_vld(out_crc_vld), .out_crc_ok(out_crc_ok)
  );

  // registered ready: downstream state plus two free slots of headroom
  always_ff @(posedge clk) begin
    if (rst) in_rdy <= 1'b0;
    else     in_rdy <= out_rdy && ($countones(full) < SLOTS - 1);
  end

  // R9
  rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !out_rdy |=> !in_rdy);

endmodule

// File: tb/tb_aal5_frame_rx.sv
module tb_aal5_frame_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0, in_soc = 1'b0, out_rdy = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_rdy, out_vld, out_den, out_sof, out_eof, out_crc_vld, out_crc_ok;
  logic [31:0] out_data;

  aal5_frame_rx dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_soc(in_soc), .in_data(in_data),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .out_vld(out_vld), .out_data(out_data),
    .out_den(out_den), .out_sof(out_sof), .out_eof(out_eof),
    .out_crc_vld(out_crc_vld), .out_crc_ok(out_crc_ok)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, unexp = 0, cycles = 0;
  bit done = 1'b0;
  // {hdr, data, den, sof, eof, crc_vld, crc_ok}
  logic [37:0] exp_q[$];

  // stimulus table: {length, seed, bad crc, idle gap after each cell, abort cell}
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{  1, 8'h11, 0, 0, 0},   // one cell, eof on first word
    '{ 40, 8'h22, 0, 0, 0},   // one cell, no pad
    '{ 41, 8'h33, 0, 0, 0},   // eof in word 10 of first cell, last cell all pad
    '{ 45, 8'h44, 0, 0, 0},   // eof on last word of first cell
    '{ 88, 8'h55, 0, 2, 0},   // two cells exactly, gaps between cells
    '{130, 8'h66, 0, 0, 0},   // three cells
    '{ 60, 8'h77, 1, 0, 0},   // corrupted CRC
    '{300, 8'h88, 0, 1, 0},   // seven cells
    '{ 90, 8'h99, 0, 0, 1},   // R7: aborted cell inside a frame
    '{ 12, 8'hAA, 0, 3, 0}
  };

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  task automatic fail_line(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) fail_line(req, what, act, exp);
  endtask

  // monitor: every output word against the expectation queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          unexp++;
          fail_line("R6", "unexpected word", out_data, 32'h0);
        end else begin
          logic [37:0] e;
          e = exp_q.pop_front();
          if (out_data !== e[36:5]) fail_line(e[37] ? "R1" : "R6", "data", out_data, e[36:5]);
          else if (out_sof !== e[3]) fail_line("R2", "sof", {31'h0, out_sof}, {31'h0, e[3]});
          else if (out_den !== e[4]) fail_line("R3", "den", {31'h0, out_den}, {31'h0, e[4]});
          else if (out_eof !== e[2]) fail_line("R4", "eof", {31'h0, out_eof}, {31'h0, e[2]});
          else if (out_crc_vld !== e[1] || out_crc_ok !== e[0])
            fail_line("R5", "crc vld/ok", {30'h0, out_crc_vld, out_crc_ok}, {30'h0, e[1:0]});
        end
      end else if (out_den || out_sof || out_eof || out_crc_vld) begin
        checks++;
        fail_line("R3", "strobe without word", {28'h0, out_den, out_sof, out_eof, out_crc_vld}, 32'h0);
      end
    end
  end

  task automatic drive(input logic soc, input logic [31:0] d);
    in_vld = 1'b1; in_soc = soc; in_data = d;
    @(negedge clk);
    in_vld = 1'b0; in_soc = 1'b0; in_data = '0;
  endtask

  task automatic wait_rdy();
    while (!in_rdy) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input int seed, input bit bad, input int gap, input bit abort);
    logic [31:0] w [0:95];
    logic [31:0] crc, hdr;
    int n, pw;
    n  = (len + 8 + 47) / 48;
    pw = (len + 3) / 4;
    for (int i = 0; i < 96; i++) w[i] = '0;
    for (int i = 0; i < len; i++) w[i/4][31 - 8*(i%4) -: 8] = 8'(seed + i*7);
    w[12*n-2] = {16'h0, 16'(len)};
    crc = '1;
    for (int i = 0; i < 12*n-1; i++)
      for (int k = 0; k < 4; k++) crc = crc_byte(crc, w[i][31 - 8*k -: 8]);
    w[12*n-1] = ~crc ^ (bad ? 32'h1 : 32'h0);
    for (int c = 0; c < n; c++) begin
      if (abort && c == 1) begin
        wait_rdy();
        drive(1'b1, 32'h0123_456C);
        for (int k = 0; k < 5; k++) drive(1'b0, 32'hDEAD_0000 + k);
      end
      wait_rdy();
      // R1: bits 2 and 3 set in every header, bit 1 only on the last cell
      hdr = 32'h0123_456C | ((c == n-1) ? 32'h2 : 32'h0);
      exp_q.push_back({1'b1, hdr, 1'b0, (c == 0), 3'b000});
      for (int j = 0; j < 12; j++) begin
        int  fw;
        bit  lastc;
        fw    = 12*c + j;
        lastc = (c == n-1);
        exp_q.push_back({1'b0, w[fw], (fw < pw) || (lastc && j >= 10), 1'b0,
                         (fw == pw-1), (lastc && j == 11), (lastc && j == 11 && !bad)});
      end
      drive(1'b1, hdr);
      for (int j = 0; j < 12; j++) drive(1'b0, w[12*c + j]);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain(input string req);
    int u0;
    u0 = unexp;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    check(req, "words left after drain", exp_q.size(), 0);
    check(req, "unexpected words", unexp - u0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      fail_line("R6", "watchdog expired", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check("R10", "out_vld in reset", out_vld, 0);
    check("R10", "out_data in reset", out_data, 0);
    check("R10", "strobes in reset", {out_den, out_sof, out_eof, out_crc_vld, out_crc_ok}, 0);
    check("R10", "in_rdy in reset", in_rdy, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "in_rdy after reset with out_rdy high", in_rdy, 1);

    for (int v = 0; v < NV; v++)
      send_frame(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VEC[v][3], VEC[v][4] != 0);
    drain("R7");

    // R8: stray words with no open cell
    for (int k = 0; k < 3; k++) drive(1'b0, 32'hBAD0_0000 + k);
    send_frame(20, 8'h5A, 0, 0, 0);
    drain("R8");

    // R9: backpressure stops new cells but not buffered words
    send_frame(88, 8'h3C, 0, 0, 0);
    out_rdy = 1'b0;
    @(negedge clk);
    check("R9", "in_rdy after out_rdy low", in_rdy, 0);
    begin
      int seen, rdy_hi;
      seen = 0; rdy_hi = 0;
      for (int i = 0; i < 30; i++) begin
        if (out_vld) seen++;
        if (in_rdy) rdy_hi++;
        @(negedge clk);
      end
      check("R9", "words forwarded while out_rdy low", (seen > 0), 1);
      check("R9", "in_rdy stayed low", rdy_hi, 0);
    end
    out_rdy = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "in_rdy back high", in_rdy, 1);

    // R11: back-to-back multi-cell frames with headroom limited by in_rdy
    send_frame(200, 8'h01, 0, 0, 0);
    send_frame(41,  8'h02, 0, 0, 0);
    send_frame(1,   8'h03, 0, 0, 0);
    send_frame(150, 8'h04, 0, 0, 0);
    drain("R11");
    finish_run();
  end

endmodule